// File: doc/BRIEF.md
# Minor-cycle phase and strobe generator

This block sequences one minor cycle of a multiplexed oscillator bank. A free-running counter splits each minor cycle into eight equal phases. Each phase is further split into four sub-phase ticks, and one tick is one clock period. Phases 0 to 3 make up the internal subcycle, when the oscillator datapath updates its phase accumulator and reads the waveform memory. Phases 4 to 7 make up the external subcycle, a window that the host may use to write into those memories.

The count is decoded into every strobe that the datapath and the row/column-multiplexed waveform memory need: the counter-advance pulse, the sum holding-register latch, the accumulator write enable, the DAC latch, the address half-select, the row strobe, the column strobe and the host-window flag. The column strobe turns on one sub-phase tick after the address select switches, so the address has time to settle. All outputs come from registers. Each output decodes the count shown on `phase_o`/`sub_o` in the same cycle.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control level or pulse. All strobes are active high.

Top module: `mc_strobe_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `phase_o` and `sub_o` to 0 and drives every strobe output low. This holds for as long as reset stays high.
- R2: Out of reset, `sub_o` goes up by one at each clock and wraps from 3 to 0. `phase_o` goes up by one when `sub_o` wraps, and it wraps from 7 to 0. A minor cycle is therefore 32 clocks.
- R3: `adv_o` is a one-clock pulse. It is high only when phase is 0 and sub is 0, and it is never high in the cycle that first leaves reset.
- R4: `hold_le_o` is high only at phase 2, sub 0. `acc_we_o` is high for all four ticks of phase 3 and low everywhere else.
- R5: `dac_le_o` is high only at phase 3, sub 3, which is the last tick of the internal subcycle.
- R6: `addr_sel_o` (0 = low address half, 1 = high half) is 1 exactly in phases 2 and 3. `ras_o` is high exactly in phases 1, 2 and 3.
- R7: `cas_o` is high from phase 2, sub 1 to the end of phase 3. It never rises in the same cycle as `addr_sel_o`, and it is only high while `ras_o` and `addr_sel_o` are high.
- R8: `ext_win_o` is high exactly in phases 4 to 7. While it is high, `adv_o`, `hold_le_o`, `acc_we_o`, `dac_le_o`, `addr_sel_o`, `ras_o` and `cas_o` are all low.
- R9: A reset that arrives mid-cycle (for example in phase 3) cuts off any strobe in progress at once. The sequence then restarts from phase 0, sub 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-phase clock (four ticks per phase) |
| rst | input | 1 | Synchronous reset, active high |
| phase_o | output | 3 | Current phase number 0..7 |
| sub_o | output | 2 | Current sub-phase tick 0..3 |
| adv_o | output | 1 | Minor-cycle counter advance pulse |
| hold_le_o | output | 1 | Sum holding-register latch enable |
| acc_we_o | output | 1 | Accumulator memory write enable |
| dac_le_o | output | 1 | DAC register latch enable |
| addr_sel_o | output | 1 | Waveform address half select, 1 = high half |
| ras_o | output | 1 | Row strobe |
| cas_o | output | 1 | Column strobe, delayed one tick after the select switch |
| ext_win_o | output | 1 | Host access window flag |

## Verification
The only input the assertions rely on is `rst`. They assume it is synchronous and stable around each rising edge. They make no assumption about how long reset lasts or when it comes, because each property is disabled while reset is high and the step checks only relate consecutive cycles out of reset. The stimulus drives `rst` only at falling edges. It mixes directed resets (at start-up, in the middle of phase 3, and held for several cycles) with sparse random one- and multi-cycle reset pulses, so the count is restarted from many different phases.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Decoded strobe set, one bit per sequencing signal.
  typedef struct packed {
    logic adv;
    logic hold;
    logic acc_we;
    logic dac;
    logic addr_sel;
    logic ras;
    logic cas;
    logic ext_win;
  } strobe_t;

endpackage

// File: rtl/mc_tick_counter.sv
module mc_tick_counter #(
  parameter int SUB_W = 2,
  parameter int PH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SUB_W-1:0] sub_q,
  output logic [PH_W-1:0]  ph_q,
  output logic [SUB_W-1:0] sub_nx,
  output logic [PH_W-1:0]  ph_nx
);

  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  // Next count: the sub tick always steps, the phase steps when the sub tick wraps.
  always_comb begin
    sub_nx = sub_q + SUB_W'(1);
    ph_nx  = (sub_q == SUB_LAST) ? ph_q + PH_W'(1) : ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      ph_q  <= '0;
    end else begin
      sub_q <= sub_nx;
      ph_q  <= ph_nx;
    end
  end

endmodule

// File: rtl/mc_strobe_decode.sv
module mc_strobe_decode
  import mc_pkg::*;
#(
  parameter int SUB_W   = 2,
  parameter int PH_W    = 3,
  parameter int CAS_DLY = 1
) (
  input  logic [SUB_W-1:0] sub_i,
  input  logic [PH_W-1:0]  ph_i,
  output strobe_t          st_o
);

  // The top phase bit selects the subcycle; the rest give the phase within it.
  localparam int IP_W = PH_W - 1;
  localparam logic [IP_W-1:0]  IP_ADV  = IP_W'(0);
  localparam logic [IP_W-1:0]  IP_ROW  = IP_W'(1);
  localparam logic [IP_W-1:0]  IP_COL  = IP_W'(2);
  localparam logic [IP_W-1:0]  IP_WB   = IP_W'(3);
  localparam logic [SUB_W-1:0] SUB_0   = '0;
  localparam logic [SUB_W-1:0] SUB_END = '1;
  localparam logic [SUB_W-1:0] CAS_S   = SUB_W'(CAS_DLY);

  logic            ext;
  logic [IP_W-1:0] ip;
  logic            col_ph;
  logic            cas_on;

  assign ext    = ph_i[PH_W-1];
  assign ip     = ph_i[IP_W-1:0];
  assign col_ph = !ext && (ip == IP_COL);

  // The column-strobe delay variant is picked by the parameter.
  generate
    if (CAS_DLY == 0) begin : g_cas_now
      assign cas_on = col_ph;
    end else begin : g_cas_late
      assign cas_on = col_ph && (sub_i >= CAS_S);
    end
  endgenerate

  always_comb begin
    st_o          = '0;
    st_o.ext_win  = ext;
    st_o.adv      = !ext && (ip == IP_ADV) && (sub_i == SUB_0);
    st_o.hold     = col_ph && (sub_i == SUB_0);
    st_o.acc_we   = !ext && (ip == IP_WB);
    st_o.dac      = !ext && (ip == IP_WB) && (sub_i == SUB_END);
    st_o.addr_sel = !ext && (ip >= IP_COL) && (ip <= IP_WB);
    st_o.ras      = !ext && (ip >= IP_ROW) && (ip <= IP_WB);
    st_o.cas      = cas_on || (!ext && (ip == IP_WB));
  end

endmodule

// File: rtl/mc_strobe_gen.sv
module mc_strobe_gen
  import mc_pkg::*;
#(
  parameter int SUB_W   = 2,
  parameter int PH_W    = 3,
  parameter int CAS_DLY = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PH_W-1:0]  phase_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             adv_o,
  output logic             hold_le_o,
  output logic             acc_we_o,
  output logic             dac_le_o,
  output logic             addr_sel_o,
  output logic             ras_o,
  output logic             cas_o,
  output logic             ext_win_o
);

  logic [SUB_W-1:0] sub_q, sub_nx;
  logic [PH_W-1:0]  ph_q, ph_nx;
  strobe_t          st_nx, st_q;

  mc_tick_counter #(.SUB_W(SUB_W), .PH_W(PH_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .sub_q  (sub_q),
    .ph_q   (ph_q),
    .sub_nx (sub_nx),
    .ph_nx  (ph_nx)
  );

  // The next count is decoded so the registered strobes line up with the count.
  mc_strobe_decode #(.SUB_W(SUB_W), .PH_W(PH_W), .CAS_DLY(CAS_DLY)) u_dec (
    .sub_i (sub_nx),
    .ph_i  (ph_nx),
    .st_o  (st_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_nx;
  end

  assign phase_o    = ph_q;
  assign sub_o      = sub_q;
  assign adv_o      = st_q.adv;
  assign hold_le_o  = st_q.hold;
  assign acc_we_o   = st_q.acc_we;
  assign dac_le_o   = st_q.dac;
  assign addr_sel_o = st_q.addr_sel;
  assign ras_o      = st_q.ras;
  assign cas_o      = st_q.cas;
  assign ext_win_o  = st_q.ext_win;

endmodule

// File: rtl/mc_strobe_gen_chk.sv
module mc_strobe_gen_chk #(
  parameter int SUB_W = 2,
  parameter int PH_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [PH_W-1:0]  phase_o,
  input logic [SUB_W-1:0] sub_o,
  input logic             adv_o,
  input logic             hold_le_o,
  input logic             acc_we_o,
  input logic             dac_le_o,
  input logic             addr_sel_o,
  input logic             ras_o,
  input logic             cas_o,
  input logic             ext_win_o
);

  localparam logic [SUB_W-1:0] SUB_END = '1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (phase_o == '0 && sub_o == '0 && !adv_o && !ras_o && !cas_o && !ext_win_o));

  p_sub_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sub_o == SUB_W'($past(sub_o) + 1'b1)));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (sub_o == SUB_END) |=> (phase_o == PH_W'($past(phase_o) + 1'b1)));

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adv_o, hold_le_o, dac_le_o}));

  p_hold_in_sel_r4: assert property (@(posedge clk) disable iff (rst)
    hold_le_o |-> (addr_sel_o && ras_o && !cas_o));

  p_dac_then_ext_r5: assert property (@(posedge clk) disable iff (rst)
    dac_le_o |=> (ext_win_o && !acc_we_o));

  p_cas_in_ras_r7: assert property (@(posedge clk) disable iff (rst)
    cas_o |-> (ras_o && addr_sel_o));

  p_cas_settle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_o) |-> $past(addr_sel_o));

  p_ext_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ext_win_o |-> !(ras_o || cas_o || acc_we_o || addr_sel_o || adv_o || hold_le_o || dac_le_o));

endmodule

bind mc_strobe_gen mc_strobe_gen_chk #(.SUB_W(SUB_W), .PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase_o    (phase_o),
  .sub_o      (sub_o),
  .adv_o      (adv_o),
  .hold_le_o  (hold_le_o),
  .acc_we_o   (acc_we_o),
  .dac_le_o   (dac_le_o),
  .addr_sel_o (addr_sel_o),
  .ras_o      (ras_o),
  .cas_o      (cas_o),
  .ext_win_o  (ext_win_o)
);

// File: tb/mc_strobe_gen_tb.sv
module mc_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] phase_o;
  logic [1:0] sub_o;
  logic adv_o, hold_le_o, acc_we_o, dac_le_o, addr_sel_o, ras_o, cas_o, ext_win_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference model state, advanced from the reset level seen at each edge.
  int m_cnt = 0;
  bit m_rst = 1'b1;

  always #5 clk = ~clk;

  mc_strobe_gen u_dut (
    .clk(clk), .rst(rst), .phase_o(phase_o), .sub_o(sub_o),
    .adv_o(adv_o), .hold_le_o(hold_le_o), .acc_we_o(acc_we_o), .dac_le_o(dac_le_o),
    .addr_sel_o(addr_sel_o), .ras_o(ras_o), .cas_o(cas_o), .ext_win_o(ext_win_o)
  );

  always @(posedge clk) begin
    if (rst) begin m_cnt = 0; m_rst = 1'b1; end
    else     begin m_cnt = (m_cnt + 1) % 32; m_rst = 1'b0; end
  end

  // Expected strobes {adv,hold,we,dac,sel,ras,cas,ext} for a count.
  function automatic logic [7:0] exp_st(int c, bit in_rst);
    int ph, s, ip;
    bit ext;
    logic [7:0] v;
    if (in_rst) return 8'h00;
    ph = c / 4; s = c % 4; ext = (ph >= 4); ip = ph % 4;
    v[7] = !ext && ip == 0 && s == 0;
    v[6] = !ext && ip == 2 && s == 0;
    v[5] = !ext && ip == 3;
    v[4] = !ext && ip == 3 && s == 3;
    v[3] = !ext && ip >= 2;
    v[2] = !ext && ip >= 1;
    v[1] = !ext && ((ip == 2 && s >= 1) || ip == 3);
    v[0] = ext;
    return v;
  endfunction

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (count %0d)", tag, nm, act, exp, m_cnt);
    end
  endtask

  task automatic check_now();
    logic [7:0] e;
    e = exp_st(m_cnt, m_rst);
    if (m_rst) begin
      chk("R1", "phase", int'(phase_o), 0);
      chk("R1", "sub", int'(sub_o), 0);
      chk("R1", "strobes", int'({adv_o, hold_le_o, acc_we_o, dac_le_o, addr_sel_o, ras_o, cas_o, ext_win_o}), 0);
    end else begin
      chk("R2", "phase", int'(phase_o), m_cnt / 4);
      chk("R2", "sub", int'(sub_o), m_cnt % 4);
      chk("R3", "adv", int'(adv_o), int'(e[7]));
      chk("R4", "hold", int'(hold_le_o), int'(e[6]));
      chk("R4", "acc_we", int'(acc_we_o), int'(e[5]));
      chk("R5", "dac", int'(dac_le_o), int'(e[4]));
      chk("R6", "addr_sel", int'(addr_sel_o), int'(e[3]));
      chk("R6", "ras", int'(ras_o), int'(e[2]));
      chk("R7", "cas", int'(cas_o), int'(e[1]));
      chk("R8", "ext_win", int'(ext_win_o), int'(e[0]));
    end
  endtask

  task automatic step(input bit r);
    rst = r;
    @(negedge clk);
    check_now();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset state held over several edges.
    for (int i = 0; i < 3; i++) step(1'b1);
    // R2..R8: two full minor cycles in order.
    for (int i = 0; i < 64; i++) step(1'b0);
    // R9: reset in the middle of phase 3, then restart.
    while (!(phase_o == 3'd3 && sub_o == 2'd1)) step(1'b0);
    step(1'b1);
    chk("R9", "acc_we cut", int'(acc_we_o), 0);
    chk("R9", "cas cut", int'(cas_o), 0);
    for (int i = 0; i < 40; i++) step(1'b0);
    // Random reset pulses of varying length.
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 149) == 0) begin
        int len = $urandom_range(1, 4);
        for (int k = 0; k < len; k++) step(1'b1);
      end else begin
        step(1'b0);
      end
    end
    finish_up();
  end

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

endmodule